// File: doc/BRIEF.md
# H-Bridge Direction and Decay Controller

This block converts a small set of digital commands (direction, enable, decay select) into the four gate commands of an external full bridge built from N-channel switches. Each half-bridge, or leg, has one high switch and one low switch. With enable high the bridge drives the load forward or in reverse. When enable is dropped, the bridge either brakes through both low switches (slow decay) or reverses its polarity so the winding current ramps down (fast decay). In fast decay, a near-zero-current indication parks the bridge with all switches off, so that the current cannot reverse.

An internal current chopper can ask for an off-time. While enable is high, that request replaces the drive with a low-side brake. If enable stays low long enough, the bridge enters a low-power standby with all switches off. Raising enable again starts a fixed wake-up period during which commands are ignored. Every change of a leg between its high and low switch passes through an all-off dead time. A fault input blanks all four gates at once and overrides everything else. All time spans are counted in clock cycles and set by parameters.

Top module: `hbridge_decay_ctrl`

## Requirements
- R1: With the controller running, `en_i`=1, `chop_req_i`=0 and `dir_i`=1, the gates settle to {ah,al,bh,bl}=4'b1001 (leg A high, leg B low).
- R2: With the controller running, `en_i`=1, `chop_req_i`=0 and `dir_i`=0, the gates settle to 4'b0110 (leg A low, leg B high).
- R3: With `en_i`=0 and `slow_sel_i`=1, the gates settle to 4'b0101 (both low switches on) for either value of `dir_i`.
- R4: With `en_i`=0 and `slow_sel_i`=0, the polarity is the opposite of the one `dir_i` selects: `dir_i`=1 gives 4'b0110 and `dir_i`=0 gives 4'b1001.
- R5: In fast decay, a `zero_cur_i` pulse of one cycle or longer turns all four gates off. They stay off until the controller leaves fast decay, which happens when `en_i` rises or `slow_sel_i` rises.
- R6: With `en_i`=1 and `chop_req_i`=1, the gates settle to 4'b0101 whatever the value of `dir_i`.
- R7: After `en_i` has been low for SLEEP_CYC consecutive cycles, the controller enters standby and all gates are off. Any high cycle on `en_i` restarts this count.
- R8: When `en_i` rises in standby, and also after reset, all gates stay off for WAKE_CYC cycles regardless of the commands. After that the bridge follows the commands.
- R9: When a leg changes from its high switch to its low switch, or the other way, both switches of that leg are off for DEAD_CYC cycles before the new switch turns on.
- R10: The high switch and the low switch of the same leg are never on together.
- R11: `fault_i`=1 turns all four gates off in the same cycle, with priority over every other input.
- R12: During reset all gates are off, and the controller leaves reset in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction: 1 forward, 0 reverse |
| en_i | input | 1 | Enable: 1 drive, 0 decay, or standby if held low |
| slow_sel_i | input | 1 | Decay when enable is low: 1 slow brake, 0 fast decay |
| chop_req_i | input | 1 | Off-time request from the internal current chopper |
| zero_cur_i | input | 1 | Load current is near zero |
| fault_i | input | 1 | Global disable |
| gate_ah_o | output | 1 | Leg A high switch on |
| gate_al_o | output | 1 | Leg A low switch on |
| gate_bh_o | output | 1 | Leg B high switch on |
| gate_bl_o | output | 1 | Leg B low switch on |

## Verification
The hardest behaviour to reach from the ports is the standby counter restart. It needs a long low stretch on `en_i`, broken by a single high cycle and then resumed. The stimulus holds enable low until just before the limit, raises it for one cycle, and then checks that the brake pattern is still present near the limit a second time before standby finally falls. The zero-current latch is reached the same way: a one-cycle pulse during fast decay, followed by a check that the bridge stays parked after the pulse has gone.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_e;

   typedef enum logic [1:0] {
      PWR_SLEEP = 2'd0,
      PWR_WAKE  = 2'd1,
      PWR_RUN   = 2'd2
   } pwr_e;
endpackage

// File: rtl/hbd_power_fsm.sv
module hbd_power_fsm
   import hbd_pkg::*;
#(
   parameter int SLEEP_CYC = 125000,
   parameter int WAKE_CYC  = 37500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output pwr_e st_o
);
   localparam int MAXC  = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (SLEEP_CYC < 2) begin : g_bad_sleep
      $error("SLEEP_CYC must be at least 2");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("WAKE_CYC must be at least 1");
   end

   pwr_e             st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PWR_SLEEP;
         cnt <= '0;
      end else begin
         unique case (st)
            PWR_RUN: begin
               if (en_i) begin
                  cnt <= '0;
               end else if (cnt == CNT_W'(SLEEP_CYC - 1)) begin
                  st  <= PWR_SLEEP;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PWR_WAKE: begin
               if (cnt == '0) begin
                  st <= PWR_RUN;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (en_i) begin
                  st  <= PWR_WAKE;
                  cnt <= CNT_W'(WAKE_CYC - 1);
               end
            end
         endcase
      end
   end

   assign st_o = st;

   // R7: standby is entered only from running with enable low
   a_r7_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PWR_SLEEP && $past(st) == PWR_RUN) |-> !$past(en_i));
   // R8: wake-up always starts from standby
   a_r8_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PWR_WAKE && $past(st) != PWR_WAKE) |-> $past(st) == PWR_SLEEP);
   // R8: running is reached only through the wake-up period
   a_r8_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PWR_RUN && $past(st) != PWR_RUN) |-> $past(st) == PWR_WAKE);
endmodule

// File: rtl/hbd_cmd_decode.sv
module hbd_cmd_decode
   import hbd_pkg::*;
#(
   parameter bit ZC_STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  pwr_e st_i,
   input  logic dir_i,
   input  logic en_i,
   input  logic slow_sel_i,
   input  logic chop_req_i,
   input  logic zero_cur_i,
   output leg_e tgt_a_o,
   output leg_e tgt_b_o
);
   logic run;
   logic fast;
   logic park;

   assign run  = (st_i == PWR_RUN);
   assign fast = run && !en_i && !slow_sel_i;

   if (ZC_STICKY) begin : g_zc_latch
      logic zc_hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     zc_hold <= 1'b0;
         else if (!fast) zc_hold <= 1'b0;
         else if (zero_cur_i) zc_hold <= 1'b1;
      end
      assign park = zc_hold || zero_cur_i;
      // R5: once latched in fast decay, the bridge stays parked
      a_r5_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (fast && $past(fast) && $past(zero_cur_i)) |-> park);
   end else begin : g_zc_live
      assign park = zero_cur_i;
   end

   always_comb begin
      tgt_a_o = LEG_OFF;
      tgt_b_o = LEG_OFF;
      if (run) begin
         if (en_i) begin
            if (chop_req_i) begin
               tgt_a_o = LEG_LO;
               tgt_b_o = LEG_LO;
            end else begin
               tgt_a_o = dir_i ? LEG_HI : LEG_LO;
               tgt_b_o = dir_i ? LEG_LO : LEG_HI;
            end
         end else if (slow_sel_i) begin
            tgt_a_o = LEG_LO;
            tgt_b_o = LEG_LO;
         end else if (!park) begin
            tgt_a_o = dir_i ? LEG_LO : LEG_HI;
            tgt_b_o = dir_i ? LEG_HI : LEG_LO;
         end
      end
   end

   // R8: outside running state nothing is requested
   a_r8_idle_targets: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (tgt_a_o == LEG_OFF && tgt_b_o == LEG_OFF));
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
   import hbd_pkg::*;
#(
   parameter int DEAD_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  leg_e tgt_i,
   output logic hi_o,
   output logic lo_o
);
   localparam int DW = $clog2(DEAD_CYC + 1);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end

   leg_e          cur;
   logic [DW-1:0] dcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= LEG_OFF;
         dcnt <= '0;
      end else if (tgt_i == cur) begin
         if (cur == LEG_OFF && dcnt != '0) dcnt <= dcnt - 1'b1;
      end else if (cur != LEG_OFF) begin
         cur  <= LEG_OFF;
         dcnt <= DW'(DEAD_CYC - 1);
      end else if (dcnt == '0) begin
         cur <= tgt_i;
      end else begin
         dcnt <= dcnt - 1'b1;
      end
   end

   assign hi_o = (cur == LEG_HI);
   assign lo_o = (cur == LEG_LO);

   // checker state: length of the current off stretch
   logic [DW:0] off_len;
   logic        seen_on;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_len <= '0;
         seen_on <= 1'b0;
      end else begin
         seen_on <= seen_on || (cur != LEG_OFF);
         if (cur != LEG_OFF) off_len <= '0;
         else if (off_len < (DW + 1)'(DEAD_CYC)) off_len <= off_len + 1'b1;
      end
   end

   // R9: a switch turns on only after a full dead time off
   a_r9_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != LEG_OFF && $past(cur) == LEG_OFF && seen_on)
         |-> off_len >= (DW + 1)'(DEAD_CYC));
   // R9: no direct change from one switch to the other
   a_r9_no_direct_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != LEG_OFF && $past(cur) != LEG_OFF) |-> cur == $past(cur));
endmodule

// File: rtl/hbridge_decay_ctrl.sv
module hbridge_decay_ctrl
   import hbd_pkg::*;
#(
   parameter int DEAD_CYC  = 125,
   parameter int SLEEP_CYC = 125000,
   parameter int WAKE_CYC  = 37500,
   parameter bit ZC_STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_i,
   input  logic en_i,
   input  logic slow_sel_i,
   input  logic chop_req_i,
   input  logic zero_cur_i,
   input  logic fault_i,
   output logic gate_ah_o,
   output logic gate_al_o,
   output logic gate_bh_o,
   output logic gate_bl_o
);
   localparam int NLEG = 2;

   pwr_e st;
   leg_e tgt [NLEG];
   logic hi  [NLEG];
   logic lo  [NLEG];

   hbd_power_fsm #(
      .SLEEP_CYC (SLEEP_CYC),
      .WAKE_CYC  (WAKE_CYC)
   ) u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .st_o  (st)
   );

   hbd_cmd_decode #(
      .ZC_STICKY (ZC_STICKY)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_i       (st),
      .dir_i      (dir_i),
      .en_i       (en_i),
      .slow_sel_i (slow_sel_i),
      .chop_req_i (chop_req_i),
      .zero_cur_i (zero_cur_i),
      .tgt_a_o    (tgt[0]),
      .tgt_b_o    (tgt[1])
   );

   for (genvar g = 0; g < NLEG; g++) begin : g_leg
      hbd_leg #(
         .DEAD_CYC (DEAD_CYC)
      ) u_leg (
         .clk   (clk),
         .rst_n (rst_n),
         .tgt_i (tgt[g]),
         .hi_o  (hi[g]),
         .lo_o  (lo[g])
      );
   end

   assign gate_ah_o = hi[0] && !fault_i;
   assign gate_al_o = lo[0] && !fault_i;
   assign gate_bh_o = hi[1] && !fault_i;
   assign gate_bl_o = lo[1] && !fault_i;

   // R10: no leg ever has both switches on
   a_r10_leg_a: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_ah_o && gate_al_o));
   a_r10_leg_b: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_bh_o && gate_bl_o));
   // R11: fault blanks every gate
   a_r11_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |-> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));
endmodule

// File: tb/tb_hbridge_decay_ctrl.sv
module tb_hbridge_decay_ctrl;
   localparam int DEAD = 4;
   localparam int SLP  = 40;
   localparam int WK   = 12;
   localparam int SETTLE = DEAD + 4;

   localparam logic [3:0] G_FWD = 4'b1001;
   localparam logic [3:0] G_REV = 4'b0110;
   localparam logic [3:0] G_BRK = 4'b0101;
   localparam logic [3:0] G_OFF = 4'b0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_i = 1'b1, en_i = 1'b1, slow_sel_i = 1'b0;
   logic chop_req_i = 1'b0, zero_cur_i = 1'b0, fault_i = 1'b0;
   logic gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o;

   int checks = 0;
   int errors = 0;
   int shoot = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] g;
      string      tag;
   } exp_t;
   exp_t q[$];
   event pushed;

   always #4 clk = ~clk;

   hbridge_decay_ctrl #(
      .DEAD_CYC  (DEAD),
      .SLEEP_CYC (SLP),
      .WAKE_CYC  (WK)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_i      (dir_i),
      .en_i       (en_i),
      .slow_sel_i (slow_sel_i),
      .chop_req_i (chop_req_i),
      .zero_cur_i (zero_cur_i),
      .fault_i    (fault_i),
      .gate_ah_o  (gate_ah_o),
      .gate_al_o  (gate_al_o),
      .gate_bh_o  (gate_bh_o),
      .gate_bl_o  (gate_bl_o)
   );

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(pushed);
         while (q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = q.pop_front();
            act = {gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o};
            checks++;
            if (act !== e.g) begin
               errors++;
               $display("FAIL %s: gates=%b expected=%b", e.tag, act, e.g);
            end
         end
      end
   end

   // R10 observed on every cycle
   always @(negedge clk) begin
      if (rst_n && ((gate_ah_o && gate_al_o) || (gate_bh_o && gate_bl_o)))
         shoot++;
   end

   task automatic expect_now(input logic [3:0] g, input string tag);
      exp_t e;
      e.g = g;
      e.tag = tag;
      q.push_back(e);
      ->pushed;
      #1;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      // R12: reset
      cyc(2);
      expect_now(G_OFF, "R12 reset off");
      rst_n = 1'b1;
      // R8: wake after reset ignores a forward command
      cyc(WK - 2);
      expect_now(G_OFF, "R8 wake after reset");
      cyc(SETTLE + 2);
      expect_now(G_FWD, "R1 forward");

      // R9: dead time on reversal, then R2
      dir_i = 1'b0;
      cyc(2);
      expect_now(G_OFF, "R9 dead gap");
      cyc(DEAD + 1);
      expect_now(G_REV, "R2 reverse");

      // R6: chopper request
      chop_req_i = 1'b1;
      cyc(SETTLE);
      expect_now(G_BRK, "R6 chop brake dir0");
      dir_i = 1'b1;
      cyc(SETTLE);
      expect_now(G_BRK, "R6 chop brake dir1");
      chop_req_i = 1'b0;
      cyc(SETTLE);
      expect_now(G_FWD, "R1 forward after chop");

      // R3: slow brake for both directions
      en_i = 1'b0; slow_sel_i = 1'b1;
      cyc(SETTLE);
      expect_now(G_BRK, "R3 slow brake dir1");
      dir_i = 1'b0;
      cyc(SETTLE);
      expect_now(G_BRK, "R3 slow brake dir0");

      // R4: fast decay reverses polarity
      en_i = 1'b1; dir_i = 1'b1;
      cyc(SETTLE);
      expect_now(G_FWD, "R1 forward again");
      en_i = 1'b0; slow_sel_i = 1'b0;
      cyc(SETTLE);
      expect_now(G_REV, "R4 fast decay dir1");

      // R5: zero-current pulse parks and stays parked
      zero_cur_i = 1'b1;
      cyc(1);
      zero_cur_i = 1'b0;
      expect_now(G_OFF, "R5 park on zero current");
      cyc(SETTLE);
      expect_now(G_OFF, "R5 park held");
      en_i = 1'b1;
      cyc(SETTLE);
      expect_now(G_FWD, "R5 release on enable");

      // R11: fault blanks in the same cycle
      fault_i = 1'b1;
      expect_now(G_OFF, "R11 fault immediate");
      cyc(3);
      expect_now(G_OFF, "R11 fault held");
      fault_i = 1'b0;
      expect_now(G_FWD, "R11 fault released");

      // R7: standby count with restart
      en_i = 1'b0; slow_sel_i = 1'b1;
      cyc(SLP - 3);
      expect_now(G_BRK, "R7 before limit");
      en_i = 1'b1;
      cyc(1);
      en_i = 1'b0;
      cyc(SLP - 3);
      expect_now(G_BRK, "R7 count restarted");
      cyc(10);
      expect_now(G_OFF, "R7 standby");

      // R8: wake from standby
      en_i = 1'b1;
      cyc(WK - 2);
      expect_now(G_OFF, "R8 wake ignores commands");
      cyc(SETTLE + 2);
      expect_now(G_FWD, "R8 runs after wake");

      // R10 summary over the whole run
      checks++;
      if (shoot != 0) begin
         errors++;
         $display("FAIL R10 shoot-through cycles=%0d expected=0", shoot);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule